// File: doc/BRIEF.md
# Signed/Unsigned Iterative Integer Divider

This block is a multi-cycle integer divider for a processor execution stage. A single datapath handles both two's-complement and unsigned division, selected per operation by a mode input. The quotient and the remainder leave on separate result ports, so an execution stage can write both back in one operation. The divider also reports overflow, quotient sign, quotient zero and divide-by-zero.

The caller presents the dividend, the divisor and the mode, and pulses `start` while the unit is idle. The unit raises `busy`. It spends one cycle converting the operands to magnitudes and one cycle per quotient bit in a restoring shift-subtract loop. A final cycle applies the signs and forms the flags. When the operation ends it drops `busy`, pulses `done` for one cycle, and holds its results until the next accepted start. In signed mode the quotient rounds toward zero, and the remainder takes the sign of the dividend.

Top module: `int_divider`

## Requirements
- R1: While reset is held, and on the first cycles after it is released, `busy`, `done`, `quotient`, `remainder`, `ovf`, `neg`, `zero` and `div_zero` are all 0.
- R2: With `is_signed`=0 and a nonzero divisor, both operands are read as unsigned W-bit values, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor.
- R3: With `is_signed`=1 and a nonzero divisor, both operands are read as W-bit two's-complement values, the quotient is truncated toward zero, and the remainder is either zero or has the sign of the dividend, so that quotient*divisor+remainder equals the dividend.
- R4: A signed division of the most negative value (bit W-1 set, all other bits clear) by all-ones (-1) gives `ovf`=1, `quotient` equal to the most negative value, and `remainder`=0.
- R5: `ovf` is 0 for every unsigned operation and for every signed operation other than the case in R4.
- R6: For a nonzero divisor, `neg` equals bit W-1 of `quotient`, and `zero` is 1 exactly when `quotient` is 0.
- R7: A zero divisor sets `div_zero`=1 and still completes with the normal latency. A nonzero divisor gives `div_zero`=0. The quotient and remainder of a division by zero are unspecified.
- R8: A start sampled while idle keeps `busy` high for exactly W+2 cycles. `done` is high for exactly one cycle, on the cycle after `busy` falls, and `done` is never high together with `busy`. The results stay stable while idle with no start.
- R9: A `start` seen while `busy` is high is ignored. The running operation finishes with its own operands and its own latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin an operation (accepted only while idle) |
| is_signed | input | 1 | 1 = two's-complement division, 0 = unsigned |
| dividend | input | W | Dividend operand |
| divisor | input | W | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the results are valid |
| quotient | output | W | Quotient result |
| remainder | output | W | Remainder result |
| ovf | output | 1 | Signed overflow (most negative value divided by -1) |
| neg | output | 1 | Quotient sign |
| zero | output | 1 | Quotient is zero |
| div_zero | output | 1 | Divisor was zero |

## Verification
The bench builds the divider at a width of 6 bits and sweeps every dividend/divisor pair in both modes. It compares each result against arithmetic done in the bench with integer division and modulo, with the operands sign-extended by hand. This catches a divider that floors negative quotients, which would show as a remainder with the divisor's sign. It also catches one that forgets to re-negate a remainder, or one that flags overflow on unsigned operands or misses the most-negative-by-minus-one case. Divide-by-zero pairs confirm that the unit raises its flag and still finishes on time instead of stalling. Every operation's latency is measured, which exposes an iteration counter that runs one step short or long. A start pulse injected mid-operation shows whether a design wrongly reloads its operands while busy.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_ITER = 2'd2,
    ST_FIX  = 2'd3
  } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
// Converts raw operands to magnitudes and records the result signs
// and special cases for the given mode.
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  input  logic         sgn_i,
  output logic [W-1:0] num_mag_o,
  output logic [W-1:0] den_mag_o,
  output logic         quo_neg_o,
  output logic         rem_neg_o,
  output logic         ovf_o,
  output logic         dz_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic num_neg, den_neg;

  always_comb begin
    num_neg   = sgn_i & num_i[W-1];
    den_neg   = sgn_i & den_i[W-1];
    num_mag_o = num_neg ? (~num_i + 1'b1) : num_i;
    den_mag_o = den_neg ? (~den_i + 1'b1) : den_i;
    quo_neg_o = num_neg ^ den_neg;
    rem_neg_o = num_neg;
    ovf_o     = sgn_i & (num_i == MOST_NEG) & (den_i == ALL_ONES);
    dz_o      = (den_i == '0);
  end
endmodule

// File: rtl/div_restore_step.sv
// One restoring shift-subtract step: produces one quotient bit.
module div_restore_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] part_i,
  input  logic [W-1:0] shreg_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] part_o,
  output logic [W-1:0] shreg_o
);
  logic [W:0] trial;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    trial   = {part_i, shreg_i[W-1]};
    diff    = trial - {1'b0, den_i};
    fits    = ~diff[W];
    part_o  = fits ? diff[W-1:0] : trial[W-1:0];
    shreg_o = {shreg_i[W-2:0], fits};
  end
endmodule

// File: rtl/div_result_fix.sv
// Applies result signs and derives the quotient flags.
module div_result_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag_i,
  input  logic [W-1:0] rem_mag_i,
  input  logic         quo_neg_i,
  input  logic         rem_neg_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         neg_o,
  output logic         zero_o
);
  always_comb begin
    quo_o  = quo_neg_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
    rem_o  = rem_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
    neg_o  = quo_o[W-1];
    zero_o = (quo_o == '0);
  end
endmodule

// File: rtl/int_divider.sv
module int_divider
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         ovf,
  output logic         neg,
  output logic         zero,
  output logic         div_zero
);
  localparam int CW  = (W > 2) ? $clog2(W) : 1;
  localparam int BCW = $clog2(W + 3) + 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);
  localparam logic [W-1:0]  MOST_NEG  = {1'b1, {(W-1){1'b0}}};

  // Reset synchronizer: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // State
  div_state_e    state_q, state_d;
  logic [CW-1:0] step_q, step_d;
  logic [W-1:0]  num_q, num_d, den_q, den_d;
  logic          sgn_q, sgn_d;
  logic [W-1:0]  part_q, part_d, shreg_q, shreg_d, dmag_q, dmag_d;
  logic          qneg_q, qneg_d, rneg_q, rneg_d, ovf_pend_q, ovf_pend_d;
  logic          dz_pend_q, dz_pend_d;
  logic [W-1:0]  quo_q, quo_d, rem_q, rem_d;
  logic          ovf_q, ovf_d, neg_q, neg_d, zero_q, zero_d, dz_q, dz_d;
  logic          done_q, done_d;

  // Sub-blocks
  logic [W-1:0] p_num_mag, p_den_mag;
  logic         p_qneg, p_rneg, p_ovf, p_dz;
  logic [W-1:0] s_part, s_shreg;
  logic [W-1:0] f_quo, f_rem;
  logic         f_neg, f_zero;

  div_operand_prep #(.W(W)) u_prep (
    .num_i(num_q), .den_i(den_q), .sgn_i(sgn_q),
    .num_mag_o(p_num_mag), .den_mag_o(p_den_mag),
    .quo_neg_o(p_qneg), .rem_neg_o(p_rneg),
    .ovf_o(p_ovf), .dz_o(p_dz)
  );

  div_restore_step #(.W(W)) u_step (
    .part_i(part_q), .shreg_i(shreg_q), .den_i(dmag_q),
    .part_o(s_part), .shreg_o(s_shreg)
  );

  div_result_fix #(.W(W)) u_fix (
    .quo_mag_i(shreg_q), .rem_mag_i(part_q),
    .quo_neg_i(qneg_q), .rem_neg_i(rneg_q),
    .quo_o(f_quo), .rem_o(f_rem), .neg_o(f_neg), .zero_o(f_zero)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    num_d      = num_q;
    den_d      = den_q;
    sgn_d      = sgn_q;
    part_d     = part_q;
    shreg_d    = shreg_q;
    dmag_d     = dmag_q;
    qneg_d     = qneg_q;
    rneg_d     = rneg_q;
    ovf_pend_d = ovf_pend_q;
    dz_pend_d  = dz_pend_q;
    quo_d      = quo_q;
    rem_d      = rem_q;
    ovf_d      = ovf_q;
    neg_d      = neg_q;
    zero_d     = zero_q;
    dz_d       = dz_q;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          num_d   = dividend;
          den_d   = divisor;
          sgn_d   = is_signed;
          state_d = ST_PREP;
        end
      end
      ST_PREP: begin
        part_d     = '0;
        shreg_d    = p_num_mag;
        dmag_d     = p_den_mag;
        qneg_d     = p_qneg;
        rneg_d     = p_rneg;
        ovf_pend_d = p_ovf;
        dz_pend_d  = p_dz;
        step_d     = '0;
        state_d    = ST_ITER;
      end
      ST_ITER: begin
        part_d  = s_part;
        shreg_d = s_shreg;
        step_d  = step_q + 1'b1;
        if (step_q == LAST_STEP) state_d = ST_FIX;
      end
      ST_FIX: begin
        quo_d   = f_quo;
        rem_d   = f_rem;
        neg_d   = f_neg;
        zero_d  = f_zero;
        ovf_d   = ovf_pend_q & ~dz_pend_q;
        dz_d    = dz_pend_q;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      num_q      <= '0;
      den_q      <= '0;
      sgn_q      <= 1'b0;
      part_q     <= '0;
      shreg_q    <= '0;
      dmag_q     <= '0;
      qneg_q     <= 1'b0;
      rneg_q     <= 1'b0;
      ovf_pend_q <= 1'b0;
      dz_pend_q  <= 1'b0;
      quo_q      <= '0;
      rem_q      <= '0;
      ovf_q      <= 1'b0;
      neg_q      <= 1'b0;
      zero_q     <= 1'b0;
      dz_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      step_q     <= step_d;
      num_q      <= num_d;
      den_q      <= den_d;
      sgn_q      <= sgn_d;
      part_q     <= part_d;
      shreg_q    <= shreg_d;
      dmag_q     <= dmag_d;
      qneg_q     <= qneg_d;
      rneg_q     <= rneg_d;
      ovf_pend_q <= ovf_pend_d;
      dz_pend_q  <= dz_pend_d;
      quo_q      <= quo_d;
      rem_q      <= rem_d;
      ovf_q      <= ovf_d;
      neg_q      <= neg_d;
      zero_q     <= zero_d;
      dz_q       <= dz_d;
      done_q     <= done_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign ovf       = ovf_q;
  assign neg       = neg_q;
  assign zero      = zero_q;
  assign div_zero  = dz_q;

  // Checker state: length of the busy window
  logic [BCW-1:0] busy_len_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  busy_len_q <= '0;
    else if (busy)   busy_len_q <= busy_len_q + 1'b1;
    else             busy_len_q <= '0;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);
  assert_no_done_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |-> !done);
  assert_busy_window_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(busy) |-> (busy_len_q == BCW'(W + 2)) && done);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && !start) |=> $stable(quotient) && $stable(remainder));
  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && start && state_q != ST_PREP) |=> $stable(num_q) && $stable(den_q) && $stable(sgn_q));
  assert_ovf_result_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && ovf) |-> (quotient == MOST_NEG) && (remainder == '0));
  assert_unsigned_no_ovf_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !sgn_q) |-> !ovf);
  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !div_zero) |-> (zero == (quotient == '0)));
endmodule

// File: tb/sim_int_divider.sv
module sim_int_divider;
  localparam int W = 6;
  localparam int LAT = W + 3;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, ovf, neg, zero, div_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  int_divider #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .ovf(ovf), .neg(neg),
    .zero(zero), .div_zero(div_zero)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int to_int(input logic [W-1:0] v, input bit s);
    int r;
    r = int'(v);
    if (s && v[W-1]) r = r - (1 << W);
    return r;
  endfunction

  // Launch one operation and wait for done; returns latency in cycles.
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit s, output int lat);
    @(negedge clk);
    dividend  = a;
    divisor   = b;
    is_signed = s;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 4 * LAT) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit s);
    int lat, ia, ib, eq, er;
    logic [W-1:0] eqw, erw;
    bit exp_ovf;
    launch(a, b, s, lat);
    chk("R8", "latency", lat, LAT);
    if (b == '0) begin
      chk("R7", "div_zero set", div_zero, 1);
    end else begin
      ia = to_int(a, s);
      ib = to_int(b, s);
      eq = ia / ib;
      er = ia % ib;
      eqw = eq[W-1:0];
      erw = er[W-1:0];
      exp_ovf = s && (a == MOST_NEG) && (b == '1);
      if (exp_ovf) begin
        chk("R4", "ovf quotient", quotient, MOST_NEG);
        chk("R4", "ovf remainder", remainder, 0);
        chk("R4", "ovf flag", ovf, 1);
      end else begin
        chk(s ? "R3" : "R2", "quotient", quotient, eqw);
        chk(s ? "R3" : "R2", "remainder", remainder, erw);
        chk("R5", "ovf clear", ovf, 0);
      end
      chk("R6", "neg flag", neg, eqw[W-1]);
      chk("R6", "zero flag", zero, (eqw == '0));
      chk("R7", "div_zero clear", div_zero, 0);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int lat;
    logic [W-1:0] q_hold;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "quotient in reset", quotient, 0);
    chk("R1", "flags in reset", {ovf, neg, zero, div_zero}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy after release", busy, 0);
    chk("R1", "remainder after release", remainder, 0);

    // R8: busy goes high right after the start cycle
    @(negedge clk);
    dividend = 6'd13; divisor = 6'd4; is_signed = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8", "busy after start", busy, 1);
    while (!done) @(negedge clk);
    chk("R2", "13/4 quotient", quotient, 3);
    @(negedge clk);
    chk("R8", "done one cycle", done, 0);
    q_hold = quotient;
    repeat (5) @(negedge clk);
    chk("R8", "results held idle", quotient, q_hold);

    // R9: start during busy is ignored
    @(negedge clk);
    dividend = 6'd27; divisor = 6'd5; is_signed = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    dividend = 6'd9; divisor = 6'd2; is_signed = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 4;
    while (!done && lat < 4 * LAT) begin
      @(negedge clk);
      lat++;
    end
    chk("R9", "latency unchanged", lat, LAT);
    chk("R9", "quotient of first op", quotient, 5);
    chk("R9", "remainder of first op", remainder, 2);
    repeat (2) @(negedge clk);
    chk("R9", "no second run", busy, 0);

    // Named corner cases
    run_op(MOST_NEG, '1, 1'b1);
    run_op(MOST_NEG, '1, 1'b0);
    run_op(6'd7, 6'd0, 1'b1);

    // Exhaustive sweep, both modes
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          run_op(a[W-1:0], b[W-1:0], s[0]);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule